// File: doc/BRIEF.md
# Buffered 10-bit PWM Output Stage

This block turns the count of an external period timer into a pulse-width modulated output. The timer supplies an 8-bit coarse count, a 2-bit fine sub-count, and a one-cycle pulse in the last cycle of each period. The fine sub-count advances on every clock, and the coarse count advances once each time the sub-count wraps. The duty value is 10 bits wide. It is compared against the extended count {coarse, fine}, so the pulse width is four times finer than the period, whose length is set in coarse steps only.

Software writes the duty into a shadow buffer through two independent write strobes. One strobe loads the upper 8 bits and the other loads the lower 2 bits. The buffer is copied into the active compare register only at a period boundary, so a change made in the middle of a period never shortens or lengthens the pulse that is in progress. The output register is set when a new period starts and cleared when the extended count reaches the active duty. The high time is therefore exactly duty fine-count cycles. When the block is disabled, the output is held low.

The block assumes that `rst_n` is asserted asynchronously and released in step with `clk`.

Top module: `pwm10_stage`

## Requirements
- R1: While `rst_n` is low and after its release, `pwm_out` is 0, and both the buffer and the active duty are cleared to 0. The first period after reset therefore stays low when no duty has been written.
- R2: At a clock edge where `period_hit` and `en` are both 1 and the buffered duty is nonzero, the buffered duty becomes active and `pwm_out` is 1 in the following cycle. That following cycle is the first cycle (count 0) of the new period.
- R3: At an edge where `en` is 1, `period_hit` is 0 and the extended count {`tmr_hi`,`tmr_lo`} plus one equals the active duty, `pwm_out` goes to 0. As a result, a duty of D gives exactly D high cycles per period when D does not exceed the period length.
- R4: A write to the buffer leaves the active duty, and so the pulse of the current period, unchanged. The new value takes effect from the next period start onward.
- R5: The duty is {`hi_data`,`lo_data`}: `hi_data` holds bits 9:2 and `lo_data` holds bits 1:0. `wr_hi` updates only the upper field and `wr_lo` updates only the lower field.
- R6: A duty greater than or equal to the period length keeps `pwm_out` at 1 for every cycle of the period. The period length is 4*(P+1) cycles for a coarse period limit P.
- R7: A duty of 0 keeps `pwm_out` at 0 for the whole period, including its first cycle.
- R8: At any edge where `en` is 0, `pwm_out` goes to 0 and stays 0, and the active duty is not reloaded. The first period start after `en` returns to 1 loads the buffer.
- R9: When a period start and a duty match fall on the same edge, the output is set if the newly loaded duty is nonzero and cleared if it is zero.
- R10: A buffer write on the same edge as a period start goes into the buffer only. The active duty for that new period is taken from the buffer contents that existed before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fine-count clock (undivided) |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Output stage enable |
| tmr_hi | input | 8 | Coarse timer count |
| tmr_lo | input | 2 | Fine sub-count, advances every clock |
| period_hit | input | 1 | High in the last cycle of a period |
| wr_hi | input | 1 | Write strobe for duty bits 9:2 |
| hi_data | input | 8 | Duty bits 9:2 |
| wr_lo | input | 1 | Write strobe for duty bits 1:0 |
| lo_data | input | 2 | Duty bits 1:0 |
| pwm_out | output | 1 | PWM output |

## Verification
Two pairs of events can fall on the same cycle: the period start with the duty match, and the period start with a buffer write. The first pair is provoked by using a duty equal to the full period length, then writing zero to the buffer mid-period. At the boundary edge the output must stay high before the edge and be low after it. The second pair is provoked by waiting until `period_hit` is visible and then writing in that same cycle. The period just started must still show the old width, and only the following period may show the new one.

// File: rtl/pwm10_pkg.sv
`timescale 1ns/1ps
package pwm10_pkg;
  localparam int DEF_HI_W = 8;
  localparam int DEF_LO_W = 2;
endpackage

// File: rtl/pwm10_duty_buf.sv
`timescale 1ns/1ps
module pwm10_duty_buf
  import pwm10_pkg::*;
#(
  parameter int HI_W = DEF_HI_W,
  parameter int LO_W = DEF_LO_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_hi,
  input  logic [HI_W-1:0]      hi_data,
  input  logic                 wr_lo,
  input  logic [LO_W-1:0]      lo_data,
  input  logic                 load,
  output logic [HI_W+LO_W-1:0] shadow,
  output logic [HI_W+LO_W-1:0] active
);
  localparam int DW = HI_W + LO_W;

  logic [HI_W-1:0] hi_q;
  logic [LO_W-1:0] lo_q;
  logic [DW-1:0]   act_q;
  logic            hi_ce, lo_ce, act_ce;
  logic [DW-1:0]   act_nxt;

  always_comb begin
    hi_ce   = wr_hi;
    lo_ce   = wr_lo;
    act_ce  = load;
    act_nxt = {hi_q, lo_q};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q  <= '0;
      lo_q  <= '0;
      act_q <= '0;
    end else begin
      if (hi_ce)  hi_q  <= hi_data;
      if (lo_ce)  lo_q  <= lo_data;
      if (act_ce) act_q <= act_nxt;
    end
  end

  assign shadow = {hi_q, lo_q};
  assign active = act_q;

  // Active duty only moves at a period start (R4, R8)
  assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(active));

  // Loaded value is the buffer as it stood before the edge (R10)
  assert_load_old_R10: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> active == $past(shadow));
endmodule

// File: rtl/pwm10_cmp.sv
`timescale 1ns/1ps
module pwm10_cmp
  import pwm10_pkg::*;
#(
  parameter int HI_W = DEF_HI_W,
  parameter int LO_W = DEF_LO_W
) (
  input  logic [HI_W-1:0]      cnt_hi,
  input  logic [LO_W-1:0]      cnt_lo,
  input  logic [HI_W+LO_W-1:0] duty,
  output logic                 hit
);
  localparam int DW = HI_W + LO_W;
  localparam logic [DW:0] ONE = DW'(1) + (DW+1)'(0);

  logic [DW:0] cnt_next;

  // One bit wider so the last count never wraps onto duty 0
  always_comb begin
    cnt_next = {1'b0, cnt_hi, cnt_lo} + ONE;
    hit      = (cnt_next == {1'b0, duty});
  end
endmodule

// File: rtl/pwm10_out_reg.sv
`timescale 1ns/1ps
module pwm10_out_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic start,
  input  logic new_nz,
  input  logic hit,
  output logic pwm
);
  logic pwm_q, pwm_d;

  always_comb begin
    pwm_d = pwm_q;
    if (!en)        pwm_d = 1'b0;
    else if (start) pwm_d = new_nz;
    else if (hit)   pwm_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pwm_q <= 1'b0;
    else        pwm_q <= pwm_d;
  end

  assign pwm = pwm_q;

  assert_off_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !pwm);

  assert_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (en && start && new_nz) |=> pwm);

  assert_zero_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (en && start && !new_nz) |=> !pwm);

  assert_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !start && hit) |=> !pwm);

  // Coincident start and match: nonzero new duty wins (R9)
  assert_coincide_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (en && start && hit && new_nz) |=> pwm);
endmodule

// File: rtl/pwm10_stage.sv
`timescale 1ns/1ps
module pwm10_stage
  import pwm10_pkg::*;
#(
  parameter int HI_W = DEF_HI_W,
  parameter int LO_W = DEF_LO_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic [HI_W-1:0] tmr_hi,
  input  logic [LO_W-1:0] tmr_lo,
  input  logic            period_hit,
  input  logic            wr_hi,
  input  logic [HI_W-1:0] hi_data,
  input  logic            wr_lo,
  input  logic [LO_W-1:0] lo_data,
  output logic            pwm_out
);
  localparam int DW = HI_W + LO_W;

  logic [DW-1:0] shadow, active;
  logic          load, hit, shadow_nz;

  always_comb begin
    load      = period_hit && en;
    shadow_nz = |shadow;
  end

  pwm10_duty_buf #(.HI_W(HI_W), .LO_W(LO_W)) u_buf (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_hi   (wr_hi),
    .hi_data (hi_data),
    .wr_lo   (wr_lo),
    .lo_data (lo_data),
    .load    (load),
    .shadow  (shadow),
    .active  (active)
  );

  pwm10_cmp #(.HI_W(HI_W), .LO_W(LO_W)) u_cmp (
    .cnt_hi (tmr_hi),
    .cnt_lo (tmr_lo),
    .duty   (active),
    .hit    (hit)
  );

  pwm10_out_reg u_out (
    .clk    (clk),
    .rst_n  (rst_n),
    .en     (en),
    .start  (period_hit),
    .new_nz (shadow_nz),
    .hit    (hit),
    .pwm    (pwm_out)
  );
endmodule

// File: tb/test_pwm10_stage.sv
`timescale 1ns/1ps
module test_pwm10_stage;
  logic       clk = 1'b0;
  logic       rst_n, en;
  logic [7:0] tmr_hi;
  logic [1:0] tmr_lo;
  logic       period_hit;
  logic       wr_hi, wr_lo;
  logic [7:0] hi_data;
  logic [1:0] lo_data;
  logic       pwm_out;

  int errors = 0;
  int checks = 0;

  logic [9:0] ext;
  logic [7:0] pr;
  bit         restart;

  always #4 clk = ~clk;

  pwm10_stage i_pwm10_stage (
    .clk(clk), .rst_n(rst_n), .en(en), .tmr_hi(tmr_hi), .tmr_lo(tmr_lo),
    .period_hit(period_hit), .wr_hi(wr_hi), .hi_data(hi_data),
    .wr_lo(wr_lo), .lo_data(lo_data), .pwm_out(pwm_out)
  );

  // {period limit P, duty, expected high cycles}; period length 4*(P+1)
  localparam logic [27:0] VEC [9] = '{
    {8'd3,  10'd5,    10'd5},
    {8'd3,  10'd1,    10'd1},
    {8'd3,  10'd15,   10'd15},
    {8'd3,  10'd16,   10'd16},
    {8'd3,  10'd20,   10'd16},
    {8'd3,  10'd1023, 10'd16},
    {8'd3,  10'd0,    10'd0},
    {8'd10, 10'd43,   10'd43},
    {8'd10, 10'd2,    10'd2}
  };

  // Timer model: updates away from the rising edge
  initial begin
    ext = '0; pr = 8'd3; restart = 1'b0;
    tmr_hi = '0; tmr_lo = '0; period_hit = 1'b0;
    forever begin
      @(negedge clk);
      if (restart) begin ext = '0; restart = 1'b0; end
      else if (ext >= {pr, 2'b11}) ext = '0;
      else ext = ext + 10'd1;
      tmr_hi = ext[9:2];
      tmr_lo = ext[1:0];
      period_hit = (ext == {pr, 2'b11});
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic write_duty(input int d);
    logic [9:0] dv;
    dv = 10'(d);
    wr_hi = 1'b1; hi_data = dv[9:2];
    wr_lo = 1'b1; lo_data = dv[1:0];
    @(posedge clk); #2;
    wr_hi = 1'b0; wr_lo = 1'b0;
  endtask

  task automatic wait_start();
    do @(posedge clk); while (!period_hit);
    #2;
  endtask

  // Called at +2 after a start edge; ends at +2 after the next start edge
  task automatic measure(output int h);
    h = 0;
    repeat (4 * int'(pr) + 4) begin
      if (pwm_out) h++;
      @(posedge clk); #2;
    end
  endtask

  initial begin
    #(8 * 150000);
    errors++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int h;
    rst_n = 1'b0; en = 1'b0;
    wr_hi = 1'b0; wr_lo = 1'b0; hi_data = '0; lo_data = '0;
    repeat (3) @(posedge clk);
    #2;
    chk("R1 reset output", int'(pwm_out), 0);
    rst_n = 1'b1;
    en = 1'b1;
    wait_start();
    measure(h);
    chk("R1 R7 cleared duty period", h, 0);

    // Table walk: widths, full-high, zero, 2-bit field
    for (int i = 0; i < 9; i++) begin
      logic [27:0] v;
      v = VEC[i];
      pr = v[27:20];
      restart = 1'b1;
      write_duty(int'(v[19:10]));
      wait_start();
      measure(h);
      checks++;
      if (h != int'(v[9:0])) begin
        errors++;
        $display("FAIL R2 R3 R5 R6 R7 vec %0d actual=%0d expected=%0d", i, h, v[9:0]);
      end
    end

    // R5: fields written separately
    pr = 8'd3; restart = 1'b1;
    write_duty(6);
    wr_lo = 1'b1; lo_data = 2'd0;
    @(posedge clk); #2; wr_lo = 1'b0;
    wait_start();
    measure(h);
    chk("R5 low field only", h, 4);
    wr_hi = 1'b1; hi_data = 8'd2;
    @(posedge clk); #2; wr_hi = 1'b0;
    wait_start();
    measure(h);
    chk("R5 high field only", h, 8);

    // R4: mid-period write does not alter the running pulse
    write_duty(5);
    wait_start();
    measure(h);
    chk("R3 duty 5", h, 5);
    h = pwm_out ? 1 : 0;
    write_duty(9);
    repeat (15) begin
      if (pwm_out) h++;
      @(posedge clk); #2;
    end
    chk("R4 running period kept", h, 5);
    measure(h);
    chk("R4 new duty next period", h, 9);

    // R10: write on the same edge as a period start
    do begin @(negedge clk); #1; end while (!period_hit);
    write_duty(12);
    measure(h);
    chk("R10 period uses old buffer", h, 9);
    measure(h);
    chk("R10 following period new", h, 12);

    // R9: start and match coincide with a zero duty waiting
    write_duty(16);
    wait_start();
    measure(h);
    chk("R6 full period high", h, 16);
    write_duty(0);
    do begin @(negedge clk); #1; end while (!period_hit);
    chk("R6 high before boundary", int'(pwm_out), 1);
    @(posedge clk); #2;
    chk("R9 zero duty wins at coincide", int'(pwm_out), 0);
    write_duty(16);
    wait_start();
    measure(h);
    chk("R9 nonzero duty set wins", h, 16);

    // R8: disable holds low; reload at first start after enable
    write_duty(5);
    wait_start();
    wait_start();
    chk("R8 high before disable", int'(pwm_out), 1);
    en = 1'b0;
    @(posedge clk); #2;
    chk("R8 low after disable", int'(pwm_out), 0);
    write_duty(7);
    h = 0;
    repeat (40) begin
      if (pwm_out) h++;
      @(posedge clk); #2;
    end
    chk("R8 held low while off", h, 0);
    en = 1'b1;
    wait_start();
    measure(h);
    chk("R8 reload after enable", h, 7);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule